// File: doc/BRIEF.md
# OTP Byte Programming Sequencer

This block programs an external one-time-programmable byte array one location at a time. For each address it drives the wanted byte onto the data bus and issues timed active-low enable pulses while the programming-voltage control is high. Between pulses it does a verify read with the voltage control low and output enable low, and it compares the result with the expected byte. The expected byte comes combinationally from a byte source indexed by the address output. When every address up to the programmed last address has been written, the block reads back the whole range at nominal supply and reports done, pass and, on failure, the failing address.

Two algorithms are selectable. Incremental mode gives short pulses until the verify passes, then one overprogram pulse whose length is the pulse count times a base unit. Margin mode turns on a margin-verify control before the first byte, gives shorter pulses with no overprogram pulse, and turns the control off again before the final read-back. All pulse widths and the read data-valid delay are parameters in clock cycles. The supply levels themselves are produced outside the block from a 2-bit select.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and while idle, the block holds prog_en_no=1, out_en_no=1, vpp_hi_o=0, data_oe_o=0, margin_o=0, supply_sel_o=0, done_o=0 and pass_o=0.
- R2: In incremental mode (mode_i=0) each short pulse lasts T_INIT cycles, and a verify read follows it before any later pulse.
- R3: In incremental mode the count starts at 1 for each byte and rises after each failed verify. When it would exceed 25, the run ends with done_o=1, pass_o=0 and fail_addr_o set to the byte, after exactly 25 short pulses on that byte.
- R4: In incremental mode a passing verify is followed by exactly one overprogram pulse of T_OVER_UNIT times the number of short pulses that byte received.
- R5: In margin mode (mode_i=1) margin_o is already 1 when the first pulse starts and stays 1 through every pulse. Each pulse lasts T_MARGIN cycles, and no overprogram pulse is issued.
- R6: In margin mode the count starts at 0 for each byte. The run fails, with fail_addr_o set, once 25 verifies of one byte have failed. A byte whose 25th verify passes does not fail.
- R7: margin_o is 0 during every final read-back and after done.
- R8: supply_sel_o is 1 (6 V / 12.5 V set) during incremental pulses and verifies, 2 (6.25 V / 12.75 V set) during margin-mode pulses and verifies, and 0 (nominal 5 V) during final read-back and at done.
- R9: After the last address, addresses 0 to last_addr_i are read at nominal supply in ascending order. The first mismatch ends the run with pass_o=0 and fail_addr_o set to that address. With no mismatch, done_o=1 and pass_o=1. done_o holds until the next start.
- R10: A program pulse is prog_en_no=0 with vpp_hi_o=1. data_oe_o=1 and data_o equals the expected byte throughout it. A read is never made with vpp_hi_o=1.
- R11: Every read (verify or final) holds prog_en_no=0, out_en_no=0 and vpp_hi_o=0 for exactly T_DV cycles, and the data is sampled in the last of these cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (taken in idle or done) |
| mode_i | input | 1 | 0 incremental, 1 margin |
| last_addr_i | input | AW | Highest address to program |
| exp_data_i | input | DW | Expected byte for addr_o |
| dev_data_i | input | DW | Data read from the array |
| addr_o | output | AW | Array address |
| data_o | output | DW | Data to program |
| data_oe_o | output | 1 | Data bus drive enable |
| prog_en_no | output | 1 | Active-low chip enable / program strobe |
| out_en_no | output | 1 | Active-low output enable |
| vpp_hi_o | output | 1 | Programming voltage high |
| supply_sel_o | output | 2 | 0 nominal, 1 incremental set, 2 margin set |
| margin_o | output | 1 | Margin-verify control |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run passed (valid with done_o) |
| fail_addr_o | output | AW | Address that failed |

## Verification
The assertions assume that mode_i and last_addr_i matter only at the start pulse, and that exp_data_i is a pure function of addr_o within a run. They also assume dev_data_i is valid by the last cycle of each read. The bench meets these assumptions by holding mode and last address constant for a whole run and by deriving the expected byte from the address and a scenario number. Its device model returns a wrong byte until a read has lasted the data-valid delay. That model programs a byte only after a set number of completed pulses, and it reads bytes back wrong at nominal supply unless they were overprogrammed or programmed with margin on.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_RECOV, ST_VERIFY, ST_OVER,
    ST_NEXT, ST_MCLR, ST_CHK_RD, ST_CHK_GAP, ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    SUP_NOM    = 2'd0,
    SUP_STD    = 2'd1,
    SUP_MARGIN = 2'd2
  } supply_e;

  localparam logic MODE_INC    = 1'b0;
  localparam logic MODE_MARGIN = 1'b1;
endpackage

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == TW'(1));

  // a window ends once per load
  assert_window_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !load_i |=> !last_o);
endmodule

// File: rtl/otp_prog_retry.sv
module otp_prog_retry #(
  parameter int MAX_TRY = 25,
  parameter int CW      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          margin_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          limit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= margin_i ? CW'(0) : CW'(1);
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  // incremental: next count would exceed MAX_TRY; margin: next count reaches it
  assign limit_o = margin_i ? (cnt_o >= CW'(MAX_TRY - 1)) : (cnt_o >= CW'(MAX_TRY));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(MAX_TRY));
  assert_no_inc_at_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !limit_o);
endmodule

// File: rtl/otp_prog_addr.sv
module otp_prog_addr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [AW-1:0] last_i,
  output logic [AW-1:0] addr_o,
  output logic          at_last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (clr_i)  addr_o <= '0;
    else if (inc_i)  addr_o <= addr_o + 1'b1;
  end

  assign at_last_o = (addr_o == last_i);

  assert_addr_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !at_last_o);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int T_INIT      = 12,
  parameter int T_OVER_UNIT = 36,
  parameter int T_MARGIN    = 6,
  parameter int T_DV        = 3,
  parameter int MAX_TRY     = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [DW-1:0] dev_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          prog_en_no,
  output logic          out_en_no,
  output logic          vpp_hi_o,
  output logic [1:0]    supply_sel_o,
  output logic          margin_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam int LONGEST = T_OVER_UNIT * MAX_TRY;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int CW      = $clog2(MAX_TRY + 1);

  state_e        state_q, state_d;
  logic          mode_q;
  logic [AW-1:0] last_q;
  logic          pass_q;
  logic [AW-1:0] fail_addr_q;

  logic          tmr_load, tmr_last;
  logic [TW-1:0] tmr_val;
  logic          rt_clr, rt_inc, rt_limit;
  logic [CW-1:0] rt_cnt;
  logic          ad_clr, ad_inc, ad_last;
  logic          rd_match;
  logic [TW-1:0] short_len, over_len;

  assign short_len = (mode_q == MODE_MARGIN) ? TW'(T_MARGIN) : TW'(T_INIT);
  assign over_len  = TW'(T_OVER_UNIT * int'(rt_cnt));
  assign rd_match  = (dev_data_i == exp_data_i);

  otp_prog_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .last_o(tmr_last)
  );

  otp_prog_retry #(.MAX_TRY(MAX_TRY), .CW(CW)) u_rt (
    .clk_i, .rst_ni, .clr_i(rt_clr), .margin_i(mode_q), .inc_i(rt_inc),
    .cnt_o(rt_cnt), .limit_o(rt_limit)
  );

  otp_prog_addr #(.AW(AW)) u_ad (
    .clk_i, .rst_ni, .clr_i(ad_clr), .inc_i(ad_inc), .last_i(last_q),
    .addr_o(addr_o), .at_last_o(ad_last)
  );

  logic start_ok, fail_now, pass_now;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = short_len;
    rt_clr   = 1'b0;
    rt_inc   = 1'b0;
    ad_clr   = 1'b0;
    ad_inc   = 1'b0;
    start_ok = 1'b0;
    fail_now = 1'b0;
    pass_now = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        start_ok = 1'b1;
        ad_clr   = 1'b1;
        state_d  = ST_SETUP;
      end
      ST_SETUP: begin
        rt_clr   = 1'b1;
        tmr_load = 1'b1;
        state_d  = ST_PULSE;
      end
      ST_PULSE: if (tmr_last) state_d = ST_RECOV;
      ST_RECOV: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(T_DV);
        state_d  = ST_VERIFY;
      end
      ST_VERIFY: if (tmr_last) begin
        if (rd_match) begin
          if (mode_q == MODE_INC) begin
            tmr_load = 1'b1;
            tmr_val  = over_len;
            state_d  = ST_OVER;
          end else begin
            state_d  = ST_NEXT;
          end
        end else if (rt_limit) begin
          fail_now = 1'b1;
          state_d  = ST_DONE;
        end else begin
          rt_inc   = 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_PULSE;
        end
      end
      ST_OVER: if (tmr_last) state_d = ST_NEXT;
      ST_NEXT: begin
        if (ad_last) begin
          if (mode_q == MODE_MARGIN) begin
            state_d = ST_MCLR;
          end else begin
            ad_clr   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TW'(T_DV);
            state_d  = ST_CHK_RD;
          end
        end else begin
          ad_inc   = 1'b1;
          rt_clr   = 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_PULSE;
        end
      end
      ST_MCLR: begin
        ad_clr   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_DV);
        state_d  = ST_CHK_RD;
      end
      ST_CHK_RD: if (tmr_last) begin
        if (!rd_match) begin
          fail_now = 1'b1;
          state_d  = ST_DONE;
        end else if (ad_last) begin
          pass_now = 1'b1;
          state_d  = ST_DONE;
        end else begin
          ad_inc   = 1'b1;
          state_d  = ST_CHK_GAP;
        end
      end
      ST_CHK_GAP: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(T_DV);
        state_d  = ST_CHK_RD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_INC;
      last_q      <= '0;
      pass_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        mode_q      <= mode_i;
        last_q      <= last_addr_i;
        pass_q      <= 1'b0;
        fail_addr_q <= '0;
      end
      if (fail_now) fail_addr_q <= addr_o;
      if (pass_now) pass_q      <= 1'b1;
    end
  end

  logic st_pgm, st_rd, st_hi;
  assign st_pgm = (state_q == ST_PULSE) || (state_q == ST_OVER);
  assign st_rd  = (state_q == ST_VERIFY) || (state_q == ST_CHK_RD);
  assign st_hi  = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_RECOV) ||
                  (state_q == ST_VERIFY) || (state_q == ST_OVER) || (state_q == ST_NEXT) ||
                  (state_q == ST_MCLR);

  assign prog_en_no   = !(st_pgm || st_rd);
  assign vpp_hi_o     = st_pgm;
  assign out_en_no    = !st_rd;
  assign data_oe_o    = st_pgm;
  assign data_o       = exp_data_i;
  assign supply_sel_o = !st_hi ? SUP_NOM : (mode_q == MODE_MARGIN) ? SUP_MARGIN : SUP_STD;
  assign margin_o     = (mode_q == MODE_MARGIN) && st_hi && (state_q != ST_MCLR);
  assign done_o       = (state_q == ST_DONE);
  assign pass_o       = done_o && pass_q;
  assign fail_addr_o  = fail_addr_q;

  assert_pulse_supply_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_no && vpp_hi_o) |-> (supply_sel_o != SUP_NOM));
  assert_no_read_at_vpp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vpp_hi_o && !out_en_no));
  assert_bus_with_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !prog_en_no);
  assert_margin_off_nominal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_sel_o == SUP_NOM) |-> !margin_o);
  assert_no_over_in_margin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OVER) |-> (mode_q == MODE_INC));
  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(pass_o) && $stable(fail_addr_o));
  assert_over_after_verify_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_OVER) |-> ($past(state_q) == ST_VERIFY));
endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int AW = 8, DW = 8;
  localparam int T_INIT = 12, T_OVER_UNIT = 36, T_MARGIN = 6, T_DV = 3, MAX_TRY = 25;
  localparam int LIMIT = 20000;

  typedef struct packed {
    logic       mode;
    logic [7:0] last;
    logic [7:0] sp_addr;
    logic [5:0] sp_need;
    logic [5:0] base_need;
    logic       drift_en;
    logic [7:0] drift_addr;
    logic [1:0] kind;       // 0 pass, 1 program fail, 2 read-back fail
    logic [7:0] fail_addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd3, 8'd0, 6'd1,  6'd1, 1'b0, 8'd0, 2'd0, 8'd0},
    '{1'b0, 8'd5, 8'd2, 6'd7,  6'd2, 1'b0, 8'd0, 2'd0, 8'd0},
    '{1'b0, 8'd2, 8'd1, 6'd30, 6'd1, 1'b0, 8'd0, 2'd1, 8'd1},
    '{1'b0, 8'd3, 8'd2, 6'd25, 6'd1, 1'b0, 8'd0, 2'd0, 8'd0},
    '{1'b1, 8'd4, 8'd0, 6'd3,  6'd3, 1'b0, 8'd0, 2'd0, 8'd0},
    '{1'b1, 8'd2, 8'd0, 6'd25, 6'd2, 1'b0, 8'd0, 2'd0, 8'd0},
    '{1'b1, 8'd3, 8'd1, 6'd26, 6'd1, 1'b0, 8'd0, 2'd1, 8'd1},
    '{1'b0, 8'd3, 8'd0, 6'd1,  6'd1, 1'b1, 8'd2, 2'd2, 8'd2},
    '{1'b1, 8'd0, 8'd0, 6'd4,  6'd4, 1'b0, 8'd0, 2'd0, 8'd0},
    '{1'b1, 8'd3, 8'd0, 6'd1,  6'd1, 1'b1, 8'd3, 2'd2, 8'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [AW-1:0] last = '0, addr, fail_addr;
  logic [DW-1:0] exp_data, dev_data = '0, data;
  logic data_oe, en_n, oe_n, vpp, margin, done, pass;
  logic [1:0] sup;
  int scen = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] expd(logic [7:0] a, int s);
    return 8'((int'(a) * 37 + s * 11 + 5) & 32'h7F);
  endfunction
  assign exp_data = expd(addr, scen);

  otp_prog_seq #(.AW(AW), .DW(DW), .T_INIT(T_INIT), .T_OVER_UNIT(T_OVER_UNIT),
    .T_MARGIN(T_MARGIN), .T_DV(T_DV), .MAX_TRY(MAX_TRY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .last_addr_i(last),
    .exp_data_i(exp_data), .dev_data_i(dev_data), .addr_o(addr), .data_o(data),
    .data_oe_o(data_oe), .prog_en_no(en_n), .out_en_no(oe_n), .vpp_hi_o(vpp),
    .supply_sel_o(sup), .margin_o(margin), .done_o(done), .pass_o(pass),
    .fail_addr_o(fail_addr));

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // device model state
  logic [7:0] mem [256];
  int  pcnt [256];
  bit  pdone [256];
  bit  firm [256];
  vec_t cur;
  bit  in_pulse, over, in_rd, await_v;
  int  pw, rw, paddr;
  int  e_short, e_over, e_vseq, e_sup, e_data, e_marg, e_rdw, e_m7, n_over, n_nom;

  task automatic model_clear();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF; pcnt[i] = 0; pdone[i] = 1'b0; firm[i] = 1'b0;
    end
    in_pulse = 0; over = 0; in_rd = 0; await_v = 0; pw = 0; rw = 0; paddr = 0;
    e_short = 0; e_over = 0; e_vseq = 0; e_sup = 0; e_data = 0; e_marg = 0;
    e_rdw = 0; e_m7 = 0; n_over = 0; n_nom = 0;
  endtask

  function automatic int need_of(int a);
    return (a == int'(cur.sp_addr)) ? int'(cur.sp_need) : int'(cur.base_need);
  endfunction

  task automatic model_step();
    logic [1:0] hi_sup;
    bit rd;
    logic [7:0] v;
    hi_sup = cur.mode ? 2'd2 : 2'd1;
    rd = !en_n && !oe_n && !vpp;
    // program pulses (R2 R4 R5 R10)
    if (!en_n && vpp) begin
      if (!in_pulse) begin
        in_pulse = 1; pw = 0; paddr = int'(addr); over = pdone[int'(addr)];
        if (await_v) e_vseq++;
        if (margin !== cur.mode) e_marg++;
      end
      pw++;
      if (sup !== hi_sup) e_sup++;
      if (!data_oe || data !== exp_data) e_data++;
    end else if (in_pulse) begin
      in_pulse = 0;
      if (over) begin
        n_over++;
        if (pw != T_OVER_UNIT * pcnt[paddr]) e_over++;
        firm[paddr] = 1;
      end else begin
        pcnt[paddr]++;
        if (pw != (cur.mode ? T_MARGIN : T_INIT)) e_short++;
        if (pcnt[paddr] >= need_of(paddr) && !pdone[paddr]) begin
          pdone[paddr] = 1; mem[paddr] = data;
          if (cur.mode) firm[paddr] = 1;
        end
        await_v = 1;
      end
    end
    // reads (R7 R8 R9 R11)
    if (rd) begin
      if (!in_rd) begin
        in_rd = 1; rw = 0;
        if (sup == 2'd0) begin
          n_nom++;
          if (margin !== 1'b0) e_m7++;
        end else begin
          await_v = 0;
          if (sup !== hi_sup) e_sup++;
        end
      end
      rw++;
    end else if (in_rd) begin
      in_rd = 0;
      if (rw != T_DV) e_rdw++;
    end
    if (rd && rw >= T_DV) begin
      v = mem[int'(addr)];
      if (sup == 2'd0 && !firm[int'(addr)]) v = v ^ 8'h01;
      if (sup == 2'd0 && cur.drift_en && addr == cur.drift_addr) v = v ^ 8'h02;
      dev_data = v;
    end else begin
      dev_data = ~exp_data;
    end
  endtask

  task automatic run_vec(int idx);
    int cyc;
    int exp_nom;
    cur = VECS[idx];
    scen = idx;
    model_clear();
    @(negedge clk);
    mode = cur.mode; last = cur.last; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model_step();
    cyc = 0;
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      model_step();
      cyc++;
    end
    chk(done == 1'b1, "R9 watchdog/done", int'(done), 1);
    chk(pass == (cur.kind == 2'd0), "R9 pass_o", int'(pass), int'(cur.kind == 2'd0));
    if (cur.kind != 2'd0)
      chk(fail_addr == cur.fail_addr, "R3 R6 R9 fail_addr_o", int'(fail_addr), int'(cur.fail_addr));
    if (cur.kind == 2'd1)
      chk(pcnt[int'(cur.fail_addr)] == MAX_TRY, cur.mode ? "R6 pulses before fail" : "R3 pulses before fail",
          pcnt[int'(cur.fail_addr)], MAX_TRY);
    if (cur.kind == 2'd0 && cur.sp_need == 6'd25)
      chk(pdone[int'(cur.sp_addr)], cur.mode ? "R6 25th verify passes" : "R3 25th pulse passes",
          int'(pdone[int'(cur.sp_addr)]), 1);
    chk(e_short == 0, cur.mode ? "R5 pulse width" : "R2 pulse width", e_short, 0);
    chk(e_vseq == 0, "R2 verify between pulses", e_vseq, 0);
    if (cur.mode) chk(n_over == 0, "R5 no overprogram", n_over, 0);
    else if (cur.kind != 2'd1) chk(n_over == int'(cur.last) + 1, "R4 overprogram count", n_over, int'(cur.last) + 1);
    chk(e_over == 0, "R4 overprogram width", e_over, 0);
    chk(e_sup == 0, "R8 elevated supply", e_sup, 0);
    chk(e_data == 0, "R10 pulse data", e_data, 0);
    chk(e_marg == 0, "R5 margin during pulses", e_marg, 0);
    chk(e_m7 == 0, "R7 margin off at read-back", e_m7, 0);
    chk(e_rdw == 0, "R11 read width", e_rdw, 0);
    exp_nom = (cur.kind == 2'd0) ? int'(cur.last) + 1 : (cur.kind == 2'd1) ? 0 : int'(cur.fail_addr) + 1;
    chk(n_nom == exp_nom, "R9 nominal reads", n_nom, exp_nom);
    chk(margin == 1'b0 && sup == 2'd0, "R7 R8 idle after done", int'(margin) * 4 + int'(sup), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
  endtask

  task automatic chk_idle(string req);
    chk({en_n, oe_n, vpp, data_oe, margin, sup, done, pass} == 9'b110000000, req,
        int'({en_n, oe_n, vpp, data_oe, margin, sup, done, pass}), 9'b110000000);
  endtask

  initial begin
    model_clear();
    cur = VECS[0];
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 idle after reset");

    for (int i = 0; i < NV; i++) run_vec(i);

    // restart from done in the other mode
    run_vec(4);
    run_vec(1);

    // reset in the middle of a pulse
    cur = VECS[1]; scen = 1; model_clear();
    mode = 1'b0; last = 8'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk(vpp == 1'b1 && en_n == 1'b0, "R10 pulse in progress", int'(vpp), 1);
    #2 rst_n = 1'b0;
    #1 chk_idle("R1 async reset mid-pulse");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 idle without start");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule